// File: doc/BRIEF.md
# Multi-Slice Event Timestamp Capture

This block time-stamps external events. It has a set of identical capture slices. Each slice picks one of the external event lines, waits for a chosen edge on that line, and records three things: the local time counter, the global system counter, and a word that describes the event. Each record goes into a small per-slice queue. Both counters come in as inputs; this block never advances them.

Software reaches each slice through its own 4 KB window in a flat register space. Through that window it sets up the slice, reads the occupancy and the oldest record, pops records one at a time, or flushes the queue. A single interrupt line is raised while any slice that has its interrupt enabled holds at least one record.

Top module: `etsc_top`

## Requirements
- R1: During reset and after reset, every configuration word reads zero, every queue is empty, every register read returns zero and the interrupt output is low.
- R2: Slice n owns addresses n*0x1000 to n*0x1000+0xFFF. The configuration word is at offset 0x0. Only bits 31, 17, 16, 9:4 and 0 are stored; every other bit reads back zero.
- R3: Configuration bits 9:4 choose the event line. Configuration bit 0 chooses the edge: 1 captures on a rising edge, 0 on a falling edge. Each event line passes through a two-flop synchronizer. The recorded counter values are the ones present at the third rising clock edge after the line changes.
- R4: Configuration bit 17 enables capture of the time counter and bit 16 enables capture of the global counter. A counter that is not enabled is stored as zero. With both bits clear, no record is queued. The time counter is read at 0x8 (low word) and 0xC (high word); the global counter is read at 0x20 (low word) and 0x24 (high word).
- R5: Bits 7:0 of the captured global-counter low word always read as zero. Only the upper 24 bits of that word are kept.
- R6: The event-type word at offset 0x10 equals the configuration word at capture time ANDed with 0x000303F1. It therefore carries the edge bit, the source number and the two counter enables.
- R7: Each queue holds 4 records and presents the oldest one. Status bits 2:0 at offset 0x4 give the occupancy and bits 31:3 read zero. The record registers read zero when the queue is empty. An event that arrives while the queue is full is dropped, unless the queue is popped in that same cycle.
- R8: Any write to the status offset 0x4 removes the oldest record. Such a write has no effect on an empty queue.
- R9: Writing exactly 0x7 to offset 0x30 empties the queue. A capture in that same cycle is discarded. Writing any other value there changes nothing.
- R10: The interrupt output is high exactly when some slice has configuration bit 31 set and a nonzero occupancy.
- R11: Addresses whose slice index is at or above the number of slices read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| event_in | input | NUM_EVENTS | Asynchronous external event lines |
| time_count | input | TIME_W | Local time counter value |
| global_count | input | GCTR_W | Global system counter value |
| reg_wr | input | 1 | Write strobe for reg_addr / reg_wdata |
| reg_addr | input | ADDR_W | Register address (slice index in bits ADDR_W-1:12) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Summary interrupt |

## Verification
The hardest situations to reach from the ports are those where several queue operations land in the same clock cycle. Examples are a capture arriving while a full queue is popped, or a flush colliding with a capture. Reaching them depends on knowing exactly when a synchronized edge reaches the queue. The bench drives the event lines and the register port from one schedule at random, with dense toggling on a few shared lines. It uses flush and pop writes heavily, so these coincidences happen many times. A behavioural model checks every read and the interrupt on every cycle. Directed phases first fill a queue past full and try non-key flush values.

// File: rtl/etsc_pkg.sv
package etsc_pkg;

   localparam int unsigned WIN_BITS = 12;

   localparam logic [11:0] OFS_CFG   = 12'h000;
   localparam logic [11:0] OFS_STAT  = 12'h004;
   localparam logic [11:0] OFS_TLO   = 12'h008;
   localparam logic [11:0] OFS_THI   = 12'h00C;
   localparam logic [11:0] OFS_ETYPE = 12'h010;
   localparam logic [11:0] OFS_GLO   = 12'h020;
   localparam logic [11:0] OFS_GHI   = 12'h024;
   localparam logic [11:0] OFS_FCLR  = 12'h030;

   localparam int unsigned CB_RISE = 0;
   localparam int unsigned CB_SRC  = 4;
   localparam int unsigned SRC_W   = 6;
   localparam int unsigned CB_GEN  = 16;
   localparam int unsigned CB_TEN  = 17;
   localparam int unsigned CB_IEN  = 31;

   localparam logic [31:0] CFG_MASK   = 32'h8003_03F1;
   localparam logic [31:0] ETYPE_MASK = 32'h0003_03F1;
   localparam logic [31:0] FCLR_KEY   = 32'h0000_0007;
   localparam logic [31:0] GLO_KEEP   = 32'hFFFF_FF00;

   typedef struct packed {
      logic [63:0] tval;
      logic [63:0] gval;
      logic [31:0] etype;
   } cap_rec_t;

endpackage

// File: rtl/etsc_sync.sv
module etsc_sync #(
   parameter int unsigned N_IN   = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] ev_in,
   output logic [N_IN-1:0] lvl,
   output logic [N_IN-1:0] lvl_d
);

   logic [N_IN-1:0] stg [STAGES+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= ev_in;
   end

   for (genvar i = 1; i <= STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   assign lvl   = stg[STAGES-1];
   assign lvl_d = stg[STAGES];

endmodule

// File: rtl/etsc_fifo.sv
module etsc_fifo
   import etsc_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = $clog2(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  cap_rec_t         din,
   output cap_rec_t         head,
   output logic [CNT_W-1:0] count
);

   cap_rec_t         mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr, wr_ptr;
   logic             pop_ok, push_ok;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign pop_ok  = pop && (count != '0);
   assign push_ok = push && ((count != CNT_W'(DEPTH)) || pop_ok);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         rd_ptr <= '0;
         wr_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= ptr_next(wr_ptr);
         if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
         count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= din;
   end

   assign head = mem[rd_ptr];

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH)); // R7
   AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr && count != '0) |=> (count == $past(count) - 1'b1)); // R8
   AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!pop && !clr && count != '0) |=> $stable(head)); // R7

endmodule

// File: rtl/etsc_slice.sv
module etsc_slice
   import etsc_pkg::*;
#(
   parameter int unsigned N_IN   = 64,
   parameter int unsigned DEPTH  = 4,
   parameter int unsigned TIME_W = 64,
   parameter int unsigned GCTR_W = 64,
   localparam int unsigned SEL_W = $clog2(N_IN),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [11:0]       ofs,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   input  logic [N_IN-1:0]   lvl,
   input  logic [N_IN-1:0]   lvl_d,
   input  logic [TIME_W-1:0] time_count,
   input  logic [GCTR_W-1:0] global_count,
   output logic              irq
);

   logic [31:0]      cfg_q;
   logic [SRC_W-1:0] src;
   logic             cur, prv, hit, push, pop, clr;
   cap_rec_t         rec, head, head_vis;
   logic [CNT_W-1:0] count;

   assign src = cfg_q[CB_SRC +: SRC_W];

   always_comb begin
      cur = 1'b0;
      prv = 1'b0;
      if (32'(src) < N_IN) begin
         cur = lvl[src[SEL_W-1:0]];
         prv = lvl_d[src[SEL_W-1:0]];
      end
   end

   assign hit  = cfg_q[CB_RISE] ? (cur & ~prv) : (~cur & prv);
   assign push = hit && (cfg_q[CB_GEN] || cfg_q[CB_TEN]);
   assign clr  = wr && (ofs == OFS_FCLR) && (wdata == FCLR_KEY);
   assign pop  = wr && (ofs == OFS_STAT);

   always_comb begin
      rec.tval  = cfg_q[CB_TEN] ? 64'(time_count) : '0;
      rec.gval  = cfg_q[CB_GEN] ? (64'(global_count) & {32'hFFFF_FFFF, GLO_KEEP}) : '0;
      rec.etype = cfg_q & ETYPE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cfg_q <= '0;
      else if (wr && ofs == OFS_CFG)   cfg_q <= wdata & CFG_MASK;
   end

   etsc_fifo #(.DEPTH(DEPTH)) i_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push),
      .pop   (pop),
      .din   (rec),
      .head  (head),
      .count (count)
   );

   assign head_vis = (count != '0) ? head : '0;

   always_comb begin
      case (ofs)
         OFS_CFG:   rdata = cfg_q;
         OFS_STAT:  rdata = 32'(count);
         OFS_TLO:   rdata = head_vis.tval[31:0];
         OFS_THI:   rdata = head_vis.tval[63:32];
         OFS_ETYPE: rdata = head_vis.etype;
         OFS_GLO:   rdata = head_vis.gval[31:0];
         OFS_GHI:   rdata = head_vis.gval[63:32];
         default:   rdata = '0;
      endcase
   end

   assign irq = cfg_q[CB_IEN] && (count != '0);

   AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0)); // R9
   AST_NO_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_q[CB_GEN] && !cfg_q[CB_TEN] && !pop && !clr) |=> $stable(count)); // R4

endmodule

// File: rtl/etsc_top.sv
module etsc_top
   import etsc_pkg::*;
#(
   parameter int unsigned NUM_SLICES  = 4,
   parameter int unsigned NUM_EVENTS  = 64,
   parameter int unsigned FIFO_DEPTH  = 4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIME_W      = 64,
   parameter int unsigned GCTR_W      = 64,
   parameter int unsigned ADDR_W      = 16,
   localparam int unsigned IDX_W      = ADDR_W - WIN_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_EVENTS-1:0] event_in,
   input  logic [TIME_W-1:0]     time_count,
   input  logic [GCTR_W-1:0]     global_count,
   input  logic                  reg_wr,
   input  logic [ADDR_W-1:0]     reg_addr,
   input  logic [31:0]           reg_wdata,
   output logic [31:0]           reg_rdata,
   output logic                  irq
);

   if (NUM_SLICES < 1 || NUM_SLICES > 16) begin : g_bad_slices
      $fatal(1, "NUM_SLICES must be 1..16");
   end
   if (ADDR_W <= WIN_BITS || NUM_SLICES > (1 << IDX_W)) begin : g_bad_addr
      $fatal(1, "ADDR_W too small for NUM_SLICES windows");
   end
   if (NUM_EVENTS < 2 || NUM_EVENTS > 64) begin : g_bad_events
      $fatal(1, "NUM_EVENTS must be 2..64");
   end
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 63) begin : g_bad_depth
      $fatal(1, "FIFO_DEPTH must be 2..63");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "SYNC_STAGES must be at least 2");
   end
   if (TIME_W < 1 || TIME_W > 64 || GCTR_W < 1 || GCTR_W > 64) begin : g_bad_cnt
      $fatal(1, "counter widths must be 1..64");
   end

   logic [NUM_EVENTS-1:0] lvl, lvl_d;
   logic [IDX_W-1:0]      idx;
   logic [11:0]           ofs;
   logic [31:0]           sl_rdata [NUM_SLICES];
   logic [NUM_SLICES-1:0] sl_irq;

   assign idx = reg_addr[ADDR_W-1:WIN_BITS];
   assign ofs = reg_addr[WIN_BITS-1:0];

   etsc_sync #(.N_IN(NUM_EVENTS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .ev_in (event_in),
      .lvl   (lvl),
      .lvl_d (lvl_d)
   );

   for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
      etsc_slice #(
         .N_IN   (NUM_EVENTS),
         .DEPTH  (FIFO_DEPTH),
         .TIME_W (TIME_W),
         .GCTR_W (GCTR_W)
      ) i_slice (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr           (reg_wr && (idx == IDX_W'(s))),
         .ofs          (ofs),
         .wdata        (reg_wdata),
         .rdata        (sl_rdata[s]),
         .lvl          (lvl),
         .lvl_d        (lvl_d),
         .time_count   (time_count),
         .global_count (global_count),
         .irq          (sl_irq[s])
      );
   end

   always_comb begin
      reg_rdata = '0;
      for (int s = 0; s < NUM_SLICES; s++) begin
         if (idx == IDX_W'(s)) reg_rdata = sl_rdata[s];
      end
   end

   assign irq = |sl_irq;

endmodule

// File: tb/test_etsc_top.sv
module test_etsc_top;

   localparam int NS  = 4;
   localparam int DEP = 4;

   typedef struct packed {
      logic [63:0] t;
      logic [63:0] g;
      logic [31:0] e;
   } rec_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] ev = '0;
   logic [63:0] tcnt = 64'h0000_0001_0000_0000;
   logic [63:0] gcnt = 64'h0000_0000_1234_5678;
   logic        reg_wr = 1'b0;
   logic [15:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int vectors = 0;
   int errors  = 0;
   bit done    = 0;

   etsc_top i_etsc_top (
      .clk          (clk),
      .rst_n        (rst_n),
      .event_in     (ev),
      .time_count   (tcnt),
      .global_count (gcnt),
      .reg_wr       (reg_wr),
      .reg_addr     (reg_addr),
      .reg_wdata    (reg_wdata),
      .reg_rdata    (reg_rdata),
      .irq          (irq)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      #2;
      tcnt = tcnt + 64'd1;
      gcnt = gcnt + 64'h0000_0001_0000_0135;
   end

   // reference model
   logic [63:0] ms1 = '0, ms2 = '0, ms3 = '0;
   logic [31:0] mcfg [NS];
   rec_t        mq   [NS][$];

   initial for (int s = 0; s < NS; s++) mcfg[s] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         ms1 = '0; ms2 = '0; ms3 = '0;
         for (int s = 0; s < NS; s++) begin
            mcfg[s] = '0;
            mq[s].delete();
         end
      end else begin
         for (int s = 0; s < NS; s++) begin
            logic [5:0] src;
            logic       cur, prv, hit, wh;
            rec_t       r;
            src = mcfg[s][9:4];
            cur = ms2[src];
            prv = ms3[src];
            hit = mcfg[s][0] ? (cur && !prv) : (!cur && prv);
            hit = hit && (mcfg[s][16] || mcfg[s][17]);
            wh  = reg_wr && (int'(reg_addr[15:12]) == s);
            r.t = mcfg[s][17] ? tcnt : 64'd0;
            r.g = mcfg[s][16] ? {gcnt[63:8], 8'h00} : 64'd0;
            r.e = mcfg[s] & 32'h0003_03F1;
            if (wh && reg_addr[11:0] == 12'h030 && reg_wdata == 32'h7) begin
               mq[s].delete();
            end else begin
               if (wh && reg_addr[11:0] == 12'h004 && mq[s].size() > 0) void'(mq[s].pop_front());
               if (hit && mq[s].size() < DEP) mq[s].push_back(r);
            end
            if (wh && reg_addr[11:0] == 12'h000) mcfg[s] = reg_wdata & 32'h8003_03F1;
         end
         ms3 = ms2; ms2 = ms1; ms1 = ev;
      end
   end

   function automatic logic [31:0] mread(input logic [15:0] a);
      int   s;
      rec_t h;
      s = int'(a[15:12]);
      if (s >= NS) return 32'h0;
      h = (mq[s].size() > 0) ? mq[s][0] : '0;
      case (a[11:0])
         12'h000: return mcfg[s];
         12'h004: return 32'(mq[s].size());
         12'h008: return h.t[31:0];
         12'h00C: return h.t[63:32];
         12'h010: return h.e;
         12'h020: return h.g[31:0];
         12'h024: return h.g[63:32];
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic mirq();
      logic v = 1'b0;
      for (int s = 0; s < NS; s++) if (mcfg[s][31] && mq[s].size() > 0) v = 1'b1;
      return v;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (!rst_n)                 return "R1";
      if (int'(a[15:12]) >= NS)   return "R11";
      case (a[11:0])
         12'h000: return "R2";
         12'h004: return "R7";
         12'h010: return "R6";
         12'h020: return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison
   always @(negedge clk) begin
      if (!done) begin
         chk(tag_of(reg_addr), reg_rdata, mread(reg_addr));
         chk(rst_n ? "R10" : "R1", 32'(irq), 32'(mirq()));
      end
   end

   task automatic wr32(input logic [15:0] a, input logic [31:0] d);
      @(posedge clk); #2;
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #2;
      reg_wr = 1'b0;
   endtask

   task automatic look(input logic [15:0] a, output logic [31:0] v);
      @(posedge clk); #2;
      reg_wr = 1'b0; reg_addr = a;
      @(negedge clk);
      v = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic pulse(input int bitn, input int hi, input int lo);
      @(posedge clk); #2; ev[bitn] = 1'b1;
      idle(hi);
      ev[bitn] = 1'b0;
      idle(lo);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      idle(5);
      rst_n = 1'b1;
      idle(2);
      look(16'h0004, v); chk("R1", v, 32'h0);

      wr32(16'h0000, 32'h8003_0031);   // rising, src 3, both counters, irq
      wr32(16'h1000, 32'h0002_0030);   // falling, src 3, time only
      wr32(16'h2000, 32'h0001_00A1);   // rising, src 10, global only
      wr32(16'h3000, 32'h8000_0031);   // rising, src 3, no counters
      pulse(3, 5, 6);
      @(posedge clk); #2; ev[10] = 1'b1;
      idle(6);

      look(16'h0004, v); chk("R3", v, 32'd1);
      look(16'h1004, v); chk("R3", v, 32'd1);
      look(16'h3004, v); chk("R4", v, 32'd0);
      look(16'h2004, v); chk("R3", v, 32'd1);
      look(16'h200C, v); chk("R4", v, 32'd0);
      look(16'h2020, v); chk("R5", v & 32'hFF, 32'd0);
      look(16'h1010, v); chk("R6", v, 32'h0002_0030);
      look(16'h1000, v); chk("R2", v, 32'h0002_0030);
      chk("R10", 32'(irq), 32'd1);

      for (int k = 0; k < 5; k++) pulse(3, 3, 3);
      idle(4);
      look(16'h0004, v); chk("R7", v, 32'd4);

      wr32(16'h0004, 32'h0);
      look(16'h0004, v); chk("R8", v, 32'd3);
      wr32(16'h0030, 32'h5);
      look(16'h0004, v); chk("R9", v, 32'd3);
      wr32(16'h0030, 32'h7);
      look(16'h0004, v); chk("R9", v, 32'd0);
      look(16'h0008, v); chk("R7", v, 32'd0);
      chk("R10", 32'(irq), 32'd0);

      wr32(16'h5000, 32'hFFFF_FFFF);
      look(16'h5000, v); chk("R11", v, 32'h0);
      wr32(16'h3000, 32'hFFFF_FFFF);
      look(16'h3000, v); chk("R2", v, 32'h8003_03F1);
      look(16'h0014, v); chk("R2", v, 32'h0);

      for (int it = 0; it < 6000; it++) begin
         logic [11:0] ofs_tab [9];
         logic [11:0] o;
         logic [3:0]  sl;
         ofs_tab = '{12'h000, 12'h004, 12'h008, 12'h00C, 12'h010,
                     12'h020, 12'h024, 12'h030, 12'h014};
         @(posedge clk); #2;
         ev[15:0] = ev[15:0] ^ 16'($urandom & $urandom & $urandom);
         o  = ofs_tab[$urandom % 9];
         sl = 4'($urandom % 6);
         reg_addr = {sl, o};
         reg_wr = (($urandom % 10) < 3);
         if (o == 12'h000)
            reg_wdata = ($urandom & 32'hFFFF_FC0F) | (32'($urandom % 16) << 4);
         else if (o == 12'h030)
            reg_wdata = ($urandom % 2) ? 32'h7 : $urandom;
         else
            reg_wdata = $urandom;
      end
      @(posedge clk); #2; reg_wr = 1'b0;
      idle(3);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule